// File: doc/BRIEF.md
# Frame Mask Centroid Tracker

This block watches a binary mask stream, one bit per pixel in raster order, produced by a noise-filtering stage. Frame boundaries are marked by a start-of-frame flag on the first beat and an end-of-frame flag on the last beat. The block treats every set pixel in a frame as part of a single detected region. While the frame streams in, it accumulates the x sum, the y sum and the number of set pixels. On the last beat of the frame it captures those totals and clears its accumulators, so the next frame can begin on the very next beat.

Two restoring dividers run side by side, each producing one quotient bit per clock. They turn the captured sums into the mean x and mean y of the set pixels. A one-cycle done strobe announces the result together with a found flag. If the frame had no set pixels, the dividers are skipped: found goes low and the previous centroid stays on the outputs. A downstream tracker or display stage can sample the centroid whenever done is high.

Top module: `mask_centroid_tracker`

## Requirements
- R1: During and after synchronous reset (`rst` high), `done_o`, `found_o`, `cx_o` and `cy_o` are all 0.
- R2: A beat with `pix_sof` high is pixel (0,0). Each later beat with `pix_valid` high advances x by 1. After x = IMG_W-1, x returns to 0 and y advances by 1. Cycles with `pix_valid` low are ignored, including any value on `pix_on`.
- R3: For a frame with N > 0 set pixels, `cx_o` equals floor(sum of the x coordinates of the set pixels / N).
- R4: For the same frame, `cy_o` equals floor(sum of the y coordinates of the set pixels / N), computed separately from x.
- R5: The beat carrying `pix_eof` counts toward its own frame. The first beat of the next frame may follow on the very next cycle, and its totals start from zero.
- R6: A `pix_sof` beat discards anything accumulated since the last end of frame, so an aborted partial frame has no effect on the next result.
- R7: When N = 0, `done_o` rises one clock edge after the edge that accepts the `pix_eof` beat, with `found_o` = 0, and `cx_o`/`cy_o` keep their previous values.
- R8: When N > 0, `done_o` rises DIV_W+2 clock edges after the edge that accepts the `pix_eof` beat, with `found_o` = 1. Here CNT_W = clog2(IMG_W*IMG_H+1) and DIV_W = CNT_W + max(clog2(IMG_W), clog2(IMG_H)).
- R9: `done_o` is high for exactly one cycle per frame. `cx_o`, `cy_o` and `found_o` change only in a cycle where `done_o` is high.
- R10: The counters hold a frame with every pixel set without overflow, and give that frame's centre correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Beat qualifier for the mask stream |
| pix_sof | input | 1 | First pixel of a frame (with pix_valid) |
| pix_eof | input | 1 | Last pixel of a frame (with pix_valid) |
| pix_on | input | 1 | Mask bit: 1 = detected pixel |
| cx_o | output | XW | Centroid x coordinate |
| cy_o | output | YW | Centroid y coordinate |
| found_o | output | 1 | Last frame held at least one set pixel |
| done_o | output | 1 | One-cycle result strobe |

## Verification
A wrong coordinate counter or a stale accumulator gives a wrong centroid on the very next done strobe. It usually shows first for single-pixel frames placed at a line wrap or at a frame corner. A divider that loses or duplicates a step gives wrong quotient bits, or shifts the strobe off its fixed DIV_W+2 latency, and both show within one frame. Accumulators that are not cleared at end of frame or at a restart surface when a full-mask frame is followed by an empty or an aborted frame.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    // Width of a pixel counter able to hold every pixel of a w x h frame.
    function automatic int unsigned cnt_bits(input int unsigned w, input int unsigned h);
        return $clog2(w * h + 1);
    endfunction

    // Dividend width shared by both divider lanes.
    function automatic int unsigned div_bits(input int unsigned cw, input int unsigned xw,
                                             input int unsigned yw);
        return cw + ((xw > yw) ? xw : yw);
    endfunction

    // Outcome captured at the end of a frame.
    typedef enum logic [1:0] {
        SNAP_NONE  = 2'd0,
        SNAP_EMPTY = 2'd1,
        SNAP_FULL  = 2'd2
    } snap_kind_e;

endpackage

// File: rtl/ctr_coord_counter.sv
module ctr_coord_counter #(
    parameter int IMG_W = 640,
    parameter int IMG_H = 480,
    parameter int XW    = $clog2(IMG_W),
    parameter int YW    = $clog2(IMG_H)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid,
    input  logic          sof,
    output logic [XW-1:0] cur_x,
    output logic [YW-1:0] cur_y
);
    logic [XW-1:0] x_q;
    logic [YW-1:0] y_q;

    // The start-of-frame beat is always pixel (0,0).
    assign cur_x = sof ? '0 : x_q;
    assign cur_y = sof ? '0 : y_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q <= '0;
            y_q <= '0;
        end else if (valid) begin
            if (cur_x == XW'(IMG_W - 1)) begin
                x_q <= '0;
                y_q <= (cur_y == YW'(IMG_H - 1)) ? '0 : cur_y + 1'b1;
            end else begin
                x_q <= cur_x + 1'b1;
                y_q <= cur_y;
            end
        end
    end
endmodule

// File: rtl/ctr_accum.sv
module ctr_accum #(
    parameter int XW   = 10,
    parameter int YW   = 9,
    parameter int CNTW = 19,
    parameter int SXW  = CNTW + XW,
    parameter int SYW  = CNTW + YW
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                valid,
    input  logic                sof,
    input  logic                eof,
    input  logic                on,
    input  logic [XW-1:0]       cur_x,
    input  logic [YW-1:0]       cur_y,
    output logic [SXW-1:0]      snap_sx,
    output logic [SYW-1:0]      snap_sy,
    output logic [CNTW-1:0]     snap_n,
    output ctr_pkg::snap_kind_e snap_kind
);
    logic [SXW-1:0]  acc_sx, nxt_sx;
    logic [SYW-1:0]  acc_sy, nxt_sy;
    logic [CNTW-1:0] acc_n, nxt_n;
    logic            hit;

    assign hit = valid && on;

    // A start-of-frame beat drops any partial totals.
    always_comb begin
        nxt_sx = (sof ? '0 : acc_sx) + (hit ? SXW'(cur_x) : '0);
        nxt_sy = (sof ? '0 : acc_sy) + (hit ? SYW'(cur_y) : '0);
        nxt_n  = (sof ? '0 : acc_n)  + (hit ? CNTW'(1) : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_sx    <= '0;
            acc_sy    <= '0;
            acc_n     <= '0;
            snap_sx   <= '0;
            snap_sy   <= '0;
            snap_n    <= '0;
            snap_kind <= ctr_pkg::SNAP_NONE;
        end else begin
            snap_kind <= ctr_pkg::SNAP_NONE;
            if (valid && eof) begin
                snap_sx   <= nxt_sx;
                snap_sy   <= nxt_sy;
                snap_n    <= nxt_n;
                snap_kind <= (nxt_n == '0) ? ctr_pkg::SNAP_EMPTY : ctr_pkg::SNAP_FULL;
                acc_sx    <= '0;
                acc_sy    <= '0;
                acc_n     <= '0;
            end else if (valid) begin
                acc_sx <= nxt_sx;
                acc_sy <= nxt_sy;
                acc_n  <= nxt_n;
            end
        end
    end
endmodule

// File: rtl/ctr_divider.sv
module ctr_divider #(
    parameter int NW = 29,
    parameter int DW = 19
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [NW-1:0] num,
    input  logic [DW-1:0] den,
    output logic [NW-1:0] quo,
    output logic          fin
);
    localparam int CW = $clog2(NW + 1);

    logic          busy;
    logic [CW-1:0] steps;
    logic [DW-1:0] rem;
    logic [DW:0]   shifted;
    logic [DW+1:0] trial;
    logic          fits;

    // Restoring step: bring in the next dividend bit, try a subtraction.
    always_comb begin
        shifted = {rem, quo[NW-1]};
        trial   = {1'b0, shifted} - {2'b00, den};
        fits    = !trial[DW+1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            steps <= '0;
            rem   <= '0;
            quo   <= '0;
            fin   <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (start && !busy) begin
                quo   <= num;
                rem   <= '0;
                steps <= CW'(NW);
                busy  <= 1'b1;
            end else if (busy) begin
                if (fits) begin
                    rem <= trial[DW-1:0];
                    quo <= {quo[NW-2:0], 1'b1};
                end else begin
                    rem <= shifted[DW-1:0];
                    quo <= {quo[NW-2:0], 1'b0};
                end
                steps <= steps - 1'b1;
                if (steps == CW'(1)) begin
                    busy <= 1'b0;
                    fin  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mask_centroid_tracker.sv
module mask_centroid_tracker #(
    parameter int IMG_W = 640,
    parameter int IMG_H = 480,
    parameter int XW    = $clog2(IMG_W),
    parameter int YW    = $clog2(IMG_H)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pix_valid,
    input  logic          pix_sof,
    input  logic          pix_eof,
    input  logic          pix_on,
    output logic [XW-1:0] cx_o,
    output logic [YW-1:0] cy_o,
    output logic          found_o,
    output logic          done_o
);
    localparam int CNTW  = ctr_pkg::cnt_bits(IMG_W, IMG_H);
    localparam int SXW   = CNTW + XW;
    localparam int SYW   = CNTW + YW;
    localparam int DIV_W = ctr_pkg::div_bits(CNTW, XW, YW);

    logic [XW-1:0]       cur_x;
    logic [YW-1:0]       cur_y;
    logic [SXW-1:0]      snap_sx;
    logic [SYW-1:0]      snap_sy;
    logic [CNTW-1:0]     snap_n;
    ctr_pkg::snap_kind_e snap_kind;
    logic [DIV_W-1:0]    qx, qy;
    logic                div_x_fin, div_y_fin, div_go;

    ctr_coord_counter #(.IMG_W(IMG_W), .IMG_H(IMG_H), .XW(XW), .YW(YW)) i_coord (
        .clk(clk), .rst(rst), .valid(pix_valid), .sof(pix_sof),
        .cur_x(cur_x), .cur_y(cur_y)
    );

    ctr_accum #(.XW(XW), .YW(YW), .CNTW(CNTW), .SXW(SXW), .SYW(SYW)) i_accum (
        .clk(clk), .rst(rst), .valid(pix_valid), .sof(pix_sof), .eof(pix_eof),
        .on(pix_on), .cur_x(cur_x), .cur_y(cur_y),
        .snap_sx(snap_sx), .snap_sy(snap_sy), .snap_n(snap_n), .snap_kind(snap_kind)
    );

    assign div_go = (snap_kind == ctr_pkg::SNAP_FULL);

    // Both lanes use the same dividend width so they finish together.
    ctr_divider #(.NW(DIV_W), .DW(CNTW)) i_div_x (
        .clk(clk), .rst(rst), .start(div_go), .num(DIV_W'(snap_sx)), .den(snap_n),
        .quo(qx), .fin(div_x_fin)
    );

    ctr_divider #(.NW(DIV_W), .DW(CNTW)) i_div_y (
        .clk(clk), .rst(rst), .start(div_go), .num(DIV_W'(snap_sy)), .den(snap_n),
        .quo(qy), .fin(div_y_fin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cx_o    <= '0;
            cy_o    <= '0;
            found_o <= 1'b0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (snap_kind == ctr_pkg::SNAP_EMPTY) begin
                found_o <= 1'b0;
                done_o  <= 1'b1;
            end else if (div_x_fin && div_y_fin) begin
                cx_o    <= qx[XW-1:0];
                cy_o    <= qy[YW-1:0];
                found_o <= 1'b1;
                done_o  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ctr_checker.sv
module ctr_checker #(
    parameter int IMG_W = 640,
    parameter int IMG_H = 480,
    parameter int XW    = 10,
    parameter int YW    = 9
) (
    input logic          clk,
    input logic          rst,
    input logic [XW-1:0] cx_o,
    input logic [YW-1:0] cy_o,
    input logic          found_o,
    input logic          done_o,
    input logic          dx_fin,
    input logic          dy_fin
);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9
    result_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(cx_o) || !$stable(cy_o) || !$stable(found_o)) |-> done_o);

    // R7
    empty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !found_o) |-> ($stable(cx_o) && $stable(cy_o)));

    // R3
    cx_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(cx_o) < IMG_W);

    // R4
    cy_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(cy_o) < IMG_H);

    // R8
    lanes_together_chk: assert property (@(posedge clk) disable iff (rst)
        dx_fin == dy_fin);
endmodule

bind mask_centroid_tracker ctr_checker #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .XW(XW), .YW(YW)
) i_ctr_checker (
    .clk(clk), .rst(rst), .cx_o(cx_o), .cy_o(cy_o), .found_o(found_o),
    .done_o(done_o), .dx_fin(div_x_fin), .dy_fin(div_y_fin)
);

// File: tb/test_mask_centroid_tracker.sv
`timescale 1ns/1ps
module test_mask_centroid_tracker;
    localparam int W   = 8;
    localparam int H   = 6;
    localparam int NP  = W * H;
    localparam int XW  = $clog2(W);
    localparam int YW  = $clog2(H);
    localparam int CW  = $clog2(NP + 1);
    localparam int DVW = CW + ((XW > YW) ? XW : YW);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pix_valid = 1'b0, pix_sof = 1'b0, pix_eof = 1'b0, pix_on = 1'b0;
    logic [XW-1:0] cx_o;
    logic [YW-1:0] cy_o;
    logic found_o, done_o;

    always #2 clk = ~clk;

    mask_centroid_tracker #(.IMG_W(W), .IMG_H(H)) i_mask_centroid_tracker (
        .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_sof(pix_sof),
        .pix_eof(pix_eof), .pix_on(pix_on), .cx_o(cx_o), .cy_o(cy_o),
        .found_o(found_o), .done_o(done_o)
    );

    int checks = 0, errors = 0, cyc = 0;
    int e_cyc[0:255], e_found[0:255], e_cx[0:255], e_cy[0:255];
    int wr = 0, rd = 0;
    int last_cx = 0, last_cy = 0;
    bit mask[0:NP-1];
    logic [15:0] lfsr = 16'hACE1;
    bit prev_done = 0;
    int prev_cx = 0, prev_cy = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic beat(input bit v, input bit s, input bit e, input bit o);
        @(posedge clk); #1;
        pix_valid = v; pix_sof = s; pix_eof = e; pix_on = o;
    endtask

    function automatic bit lfsr_bit();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    // Send the current mask; gap_every > 0 inserts invalid beats with pix_on high.
    task automatic send_frame(input int gap_every, input int abort_len);
        int n = 0, sx = 0, sy = 0;
        for (int i = 0; i < abort_len; i++) beat(1, i == 0, 0, 1);
        for (int p = 0; p < NP; p++) begin
            if (mask[p]) begin n++; sx += p % W; sy += p / W; end
        end
        for (int p = 0; p < NP; p++) begin
            if (gap_every > 0 && (p % gap_every) == gap_every - 1) beat(0, 0, 0, 1);
            beat(1, p == 0, p == NP - 1, mask[p]);
            if (p == NP - 1) begin
                if (n == 0) begin
                    e_cyc[wr] = cyc + 1 + 1; e_found[wr] = 0;
                    e_cx[wr] = last_cx; e_cy[wr] = last_cy;
                end else begin
                    e_cyc[wr] = cyc + 1 + DVW + 2; e_found[wr] = 1;
                    last_cx = sx / n; last_cy = sy / n;
                    e_cx[wr] = last_cx; e_cy[wr] = last_cy;
                end
                wr++;
            end
        end
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) beat(0, 0, 0, 0);
    endtask

    // Result monitor, sampling away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            if (done_o) begin
                if (rd >= wr) chk(0, "R9 unexpected done", 1, 0);
                else begin
                    chk(cyc == e_cyc[rd], e_found[rd] ? "R8 latency" : "R7 latency", cyc, e_cyc[rd]);
                    chk(found_o == e_found[rd], "R7/R8 found", found_o, e_found[rd]);
                    chk(cx_o == e_cx[rd], "R3 cx (R10 R5 R6 R2)", cx_o, e_cx[rd]);
                    chk(cy_o == e_cy[rd], "R4 cy (R10 R5 R6 R2)", cy_o, e_cy[rd]);
                    rd++;
                end
                if (prev_done) chk(0, "R9 done width", 2, 1);
            end else begin
                if (cx_o != prev_cx || cy_o != prev_cy)
                    chk(0, "R9 output changed without done", cx_o, prev_cx);
            end
            prev_done = done_o; prev_cx = cx_o; prev_cy = cy_o;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        @(negedge clk);
        chk(done_o == 0 && found_o == 0, "R1 flags in reset", {done_o, found_o}, 0);
        chk(cx_o == 0 && cy_o == 0, "R1 centroid in reset", {cx_o, cy_o}, 0);
        @(posedge clk); #1 rst = 1'b0;
        idle(2);

        // R7 empty frame first: centroid held at reset value
        for (int p = 0; p < NP; p++) mask[p] = 0;
        send_frame(0, 0); idle(20);

        // R2 sweep of every single-pixel position, back-to-back frames (R5)
        for (int q = 0; q < NP; q++) begin
            for (int p = 0; p < NP; p++) mask[p] = (p == q);
            send_frame(0, 0);
        end
        idle(20);

        // R10 full frame, then R7 empty frame holds its centre
        for (int p = 0; p < NP; p++) mask[p] = 1;
        send_frame(0, 0);
        for (int p = 0; p < NP; p++) mask[p] = 0;
        send_frame(0, 0); idle(20);

        // R3 R4 checkerboard and rectangle
        for (int p = 0; p < NP; p++) mask[p] = ((p % W) + (p / W)) % 2 == 0;
        send_frame(0, 0);
        for (int p = 0; p < NP; p++) mask[p] = (p % W >= 2 && p % W <= 6 && p / W >= 1 && p / W <= 4);
        send_frame(0, 0); idle(20);

        // R2 gaps with pix_on high while invalid; pseudo-random masks
        for (int f = 0; f < 6; f++) begin
            for (int p = 0; p < NP; p++) mask[p] = lfsr_bit();
            send_frame((f % 3) + 2, 0);
        end
        idle(20);

        // R6 aborted partial frames before a real frame
        for (int p = 0; p < NP; p++) mask[p] = (p == NP - 1);
        send_frame(0, 20);
        for (int p = 0; p < NP; p++) mask[p] = (p == 0);
        send_frame(3, 37);
        for (int p = 0; p < NP; p++) mask[p] = 0;
        send_frame(0, 30);
        idle(30);

        chk(rd == wr, "R9 every frame got one done", rd, wr);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule